// File: doc/BRIEF.md
# Sinc Bitstream Decimator with Gain and Offset Correction

This block turns the one-bit output of a sigma-delta feedback loop into signed multi-bit samples. Each bit that arrives on a bit-rate clock enable counts as +1 or -1. The bits feed a cascade of integrators that run at the bit rate. A comb cascade runs once per output period and completes a sinc (CIC) filter. The filter order can be second or third. The decimation ratio can be 16 or 32. Both are selected at run time.

The filtered value then passes through a correction stage with two parts. First it is multiplied by an unsigned 16-bit gain in 1.15 fixed point, where 0x8000 means unity. Then a signed 16-bit offset is added. The result is fitted to a selected output word length of 8, 16 or 32 bits, either by saturating or by wrapping, and is sign-extended to a 32-bit port. A one-cycle valid strobe marks each new sample.

Changing the order or the ratio clears all filter state. Valid strobes are then withheld until the filter has settled again.

Top module: `sinc_decim_top`

## Requirements
- R1: Input bit 1 counts as +1 and bit 0 as -1. Take gain 0x8000, offset 0, and a 4-bit pattern repeated without end. The settled output then equals R^N times the mean input value, where R is the ratio and N is the order. For example, all ones at N=3, R=32 gives +32768.
- R2: `order_sel` = 0 gives a second-order filter and `order_sel` = 1 gives a third-order filter.
- R3: `ratio_sel` = 0 decimates by 16 and `ratio_sel` = 1 decimates by 32. `sample_valid` is a single-cycle pulse that occurs once per R strobes of `bit_en`.
- R4: A change of `order_sel` or `ratio_sel` clears the integrators, the combs and the correction pipeline. The next N+1 output periods give no valid. The first new valid follows the (N+2)·R-th strobe counted from the change.
- R5: Output value = floor(filter × gain / 2^15) + offset. `gain` is unsigned. `offset` is signed two's complement. The shift is arithmetic, so negative products round toward minus infinity.
- R6: `width_sel` = 00 selects 8 bits, 01 selects 16 bits, and 10 or 11 selects 32 bits. `sample_out` is always sign-extended from the selected width to 32 bits.
- R7: With `clip_en` = 1 the result saturates to [-2^(w-1), 2^(w-1)-1]. With `clip_en` = 0 only the low w bits are kept, read as signed.
- R8: While `rst` is high, `sample_valid` and `sample_out` are 0. Reset loads the third-order, ratio-32 setting. With matching inputs, the first valid follows strobe 5·32 = 160 counted from the release of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-rate strobe; `bit_in` is taken when high |
| bit_in | input | 1 | Sigma-delta bitstream |
| order_sel | input | 1 | 0: second order, 1: third order |
| ratio_sel | input | 1 | 0: ratio 16, 1: ratio 32 |
| gain | input | 16 | Unsigned gain, 1.15 fixed point |
| offset | input | 16 | Signed offset added after the gain |
| clip_en | input | 1 | 1: saturate, 0: wrap |
| width_sel | input | 2 | Output word length code |
| sample_out | output | 32 | Corrected sample, sign-extended |
| sample_valid | output | 1 | One-cycle strobe per new sample |

## Verification
The assertions check four things on every cycle:
- no two valid strobes occur in adjacent cycles;
- a configuration change always flushes the valid in the following cycle and keeps the settling counter bounded;
- every released filter value lies within ±R^N for the order and ratio in force;
- 8-bit results are properly sign-extended and stay within range when clipping is on.

Only the bench scenarios can show the exact numbers, because the expected values depend on stream history. These cover the DC and fractional-density gains for all four order/ratio pairs, the floor rounding of the scaling, saturation against wrapping, the two equivalent 32-bit codes, and the strobe counts at which the first sample appears after reset and after a reconfiguration.

// File: rtl/sinc_pkg.sv
package sinc_pkg;
  localparam int MAX_ORD   = 3;
  localparam int LOG2_RMAX = 5;
  localparam int FW        = MAX_ORD * LOG2_RMAX + 2;
  localparam int GW        = 16;
  localparam int OW        = 32;
  localparam int SEL_W     = $clog2(MAX_ORD + 1);
  localparam int WL_SHORT  = 8;
  localparam int WL_MID    = 16;
  localparam int WL_LONG   = 32;

  typedef enum logic [1:0] {
    WSEL_8  = 2'b00,
    WSEL_16 = 2'b01,
    WSEL_32 = 2'b10,
    WSEL_32B = 2'b11
  } wsel_e;
endpackage

// File: rtl/sinc_integ_chain.sv
module sinc_integ_chain #(
  parameter int ORD = 3,
  parameter int W   = 17
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 en,
  input  logic                 bit_in,
  output logic [ORD-1:0][W-1:0] acc
);
  logic [W-1:0] step;
  assign step = bit_in ? W'(1) : {W{1'b1}};

  for (genvar k = 0; k < ORD; k++) begin : g_int
    logic [W-1:0] sum_r;
    logic [W-1:0] add_in;
    if (k == 0) begin : g_first
      assign add_in = step;
    end else begin : g_next
      assign add_in = acc[k-1];
    end
    always_ff @(posedge clk) begin
      if (rst || clr) sum_r <= '0;
      else if (en)    sum_r <= sum_r + add_in;
    end
    assign acc[k] = sum_r;
  end
endmodule

// File: rtl/sinc_comb_chain.sv
module sinc_comb_chain #(
  parameter int ORD = 3,
  parameter int W   = 17,
  localparam int SW = $clog2(ORD + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  input  logic          pass,
  input  logic [SW-1:0] nsel,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  filt,
  output logic          filt_vld
);
  logic [ORD:0][W-1:0] stage;
  assign stage[0] = din;

  for (genvar k = 0; k < ORD; k++) begin : g_comb
    logic [W-1:0] dly;
    assign stage[k+1] = stage[k] - dly;
    always_ff @(posedge clk) begin
      if (rst || clr) dly <= '0;
      else if (tick)  dly <= stage[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      filt     <= '0;
      filt_vld <= 1'b0;
    end else begin
      filt_vld <= tick && pass;
      if (tick) filt <= stage[nsel];
    end
  end
endmodule

// File: rtl/sinc_scale.sv
module sinc_scale
  import sinc_pkg::*;
#(
  parameter int IW  = FW,
  parameter int GWD = GW,
  parameter int OWD = OW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           in_vld,
  input  logic [IW-1:0]  in_val,
  input  logic [GWD-1:0] gain,
  input  logic [GWD-1:0] offset,
  input  logic           clip_en,
  input  logic [1:0]     width_sel,
  output logic [OWD-1:0] out_val,
  output logic           out_vld
);
  localparam int PW = IW + GWD + 1;
  localparam int XW = PW + 1;

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] prod_r;
  logic                 a_vld;
  logic signed [XW-1:0] sum;
  logic                 clip_r;
  logic [1:0]           wsel_r;
  int                   wbits;

  assign prod = $signed({{(PW-IW){in_val[IW-1]}}, in_val}) *
                $signed({{(PW-GWD){1'b0}}, gain});

  always_ff @(posedge clk) begin
    if (rst || clr) a_vld <= 1'b0;
    else            a_vld <= in_vld;
    prod_r <= prod >>> (GWD - 1);
  end

  function automatic logic [OWD-1:0] fit_word(input logic signed [XW-1:0] v,
                                              input int w, input logic clip);
    logic signed [XW-1:0] hi;
    logic signed [XW-1:0] lo;
    logic signed [XW-1:0] t;
    hi = $signed((XW'(1) << (w - 1)) - XW'(1));
    lo = -hi - XW'(1);
    if (clip) begin
      if (v > hi)      t = hi;
      else if (v < lo) t = lo;
      else             t = v;
    end else begin
      t = v <<< (XW - w);
      t = t >>> (XW - w);
    end
    return t[OWD-1:0];
  endfunction

  always_comb begin
    case (wsel_e'(width_sel))
      WSEL_8:  wbits = WL_SHORT;
      WSEL_16: wbits = WL_MID;
      default: wbits = WL_LONG;
    endcase
    sum = $signed({prod_r[PW-1], prod_r}) +
          $signed({{(XW-GWD){offset[GWD-1]}}, offset});
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      out_vld <= 1'b0;
      out_val <= '0;
      clip_r  <= 1'b0;
      wsel_r  <= 2'b00;
    end else begin
      out_vld <= a_vld;
      clip_r  <= clip_en;
      wsel_r  <= width_sel;
      if (a_vld) out_val <= fit_word(sum, wbits, clip_en);
    end
  end

  AST_SAT_RANGE: assert property (@(posedge clk) disable iff (rst)
    out_vld && clip_r && wsel_r == 2'b00 |->
      ($signed(out_val) <= (2**(WL_SHORT-1)) - 1) &&
      ($signed(out_val) >= -(2**(WL_SHORT-1)))); // R7
  AST_SIGN_EXT: assert property (@(posedge clk) disable iff (rst)
    out_vld && wsel_r == 2'b00 |->
      (&out_val[OWD-1:WL_SHORT-1]) || !(|out_val[OWD-1:WL_SHORT-1])); // R6
endmodule

// File: rtl/sinc_decim_top.sv
module sinc_decim_top
  import sinc_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_en,
  input  logic          bit_in,
  input  logic          order_sel,
  input  logic          ratio_sel,
  input  logic [GW-1:0] gain,
  input  logic [GW-1:0] offset,
  input  logic          clip_en,
  input  logic [1:0]    width_sel,
  output logic [OW-1:0] sample_out,
  output logic          sample_valid
);
  localparam int WARM_W = $clog2(MAX_ORD + 2);

  logic                      ord_q, rat_q, cfg_chg, tick, pass;
  logic [LOG2_RMAX-1:0]      ph, ph_last;
  logic [WARM_W-1:0]         warm;
  logic [SEL_W-1:0]          nsel, nsel_in;
  logic [MAX_ORD-1:0][FW-1:0] acc;
  logic [FW-1:0]             comb_in, filt;
  logic                      filt_vld;

  assign cfg_chg = (order_sel != ord_q) || (ratio_sel != rat_q);
  assign nsel    = ord_q ? SEL_W'(MAX_ORD) : SEL_W'(MAX_ORD - 1);
  assign nsel_in = order_sel ? SEL_W'(MAX_ORD) : SEL_W'(MAX_ORD - 1);
  assign ph_last = rat_q ? {LOG2_RMAX{1'b1}} : {1'b0, {(LOG2_RMAX-1){1'b1}}};
  assign tick    = bit_en && (ph == ph_last) && !cfg_chg;
  assign pass    = (warm == '0);
  assign comb_in = acc[nsel - SEL_W'(1)];

  always_ff @(posedge clk) begin
    if (rst) begin
      ord_q <= 1'b1;
      rat_q <= 1'b1;
      ph    <= '0;
      warm  <= WARM_W'(MAX_ORD + 1);
    end else begin
      ord_q <= order_sel;
      rat_q <= ratio_sel;
      if (cfg_chg) begin
        ph   <= '0;
        warm <= WARM_W'(nsel_in) + WARM_W'(1);
      end else begin
        if (bit_en) ph <= (ph == ph_last) ? '0 : ph + 1'b1;
        if (tick && warm != '0) warm <= warm - 1'b1;
      end
    end
  end

  sinc_integ_chain #(.ORD(MAX_ORD), .W(FW)) integ_i (
    .clk(clk), .rst(rst), .clr(cfg_chg), .en(bit_en), .bit_in(bit_in), .acc(acc)
  );

  sinc_comb_chain #(.ORD(MAX_ORD), .W(FW)) comb_i (
    .clk(clk), .rst(rst), .clr(cfg_chg), .tick(tick), .pass(pass),
    .nsel(nsel), .din(comb_in), .filt(filt), .filt_vld(filt_vld)
  );

  sinc_scale #(.IW(FW), .GWD(GW), .OWD(OW)) scale_i (
    .clk(clk), .rst(rst), .clr(cfg_chg), .in_vld(filt_vld), .in_val(filt),
    .gain(gain), .offset(offset), .clip_en(clip_en), .width_sel(width_sel),
    .out_val(sample_out), .out_vld(sample_valid)
  );

  AST_SINGLE_VALID: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> !sample_valid); // R3
  AST_FLUSH_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    cfg_chg |=> !sample_valid); // R4
  AST_WARM_LIMIT: assert property (@(posedge clk) disable iff (rst)
    warm <= WARM_W'(MAX_ORD + 1)); // R4
  AST_FILT_BOUND: assert property (@(posedge clk) disable iff (rst)
    filt_vld |->
      ($signed(filt) <= $signed(FW'(1) << ((ord_q ? 3 : 2) * (rat_q ? LOG2_RMAX : LOG2_RMAX - 1)))) &&
      ($signed(filt) >= -$signed(FW'(1) << ((ord_q ? 3 : 2) * (rat_q ? LOG2_RMAX : LOG2_RMAX - 1))))); // R1
endmodule

// File: tb/sinc_decim_top_tb.sv
module sinc_decim_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_en = 1'b0;
  logic        bit_in = 1'b0;
  logic        order_sel = 1'b1;
  logic        ratio_sel = 1'b1;
  logic [15:0] gain = 16'h8000;
  logic [15:0] offset = 16'h0000;
  logic        clip_en = 1'b1;
  logic [1:0]  width_sel = 2'b10;
  logic [31:0] sample_out;
  logic        sample_valid;

  int checks = 0;
  int errors = 0;
  int strobes = 0;
  int pidx = 0;
  logic [3:0] pat = 4'hF;
  logic timed_out = 1'b0;

  always #5 clk = ~clk;

  sinc_decim_top dut_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
    .order_sel(order_sel), .ratio_sel(ratio_sel), .gain(gain), .offset(offset),
    .clip_en(clip_en), .width_sel(width_sel),
    .sample_out(sample_out), .sample_valid(sample_valid)
  );

  typedef struct packed {
    logic        o3;
    logic        r32;
    logic [3:0]  pt;
    logic [15:0] g;
    logic [15:0] off;
    logic        clip;
    logic [1:0]  wl;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 4'hF, 16'h8000, 16'h0000, 1'b1, 2'b10}, // +32768   R1 R2 R3
    '{1'b0, 1'b0, 4'hF, 16'h8000, 16'h0000, 1'b1, 2'b01}, // +256     R2 R3
    '{1'b0, 1'b1, 4'h0, 16'h8000, 16'h0000, 1'b1, 2'b01}, // -1024    R1
    '{1'b1, 1'b0, 4'h7, 16'h8000, 16'h0010, 1'b1, 2'b01}, // 2064     R5
    '{1'b1, 1'b1, 4'hF, 16'h8000, 16'h0000, 1'b1, 2'b01}, // 32767    R7
    '{1'b1, 1'b1, 4'hF, 16'h8000, 16'h0000, 1'b0, 2'b01}, // -32768   R7
    '{1'b1, 1'b1, 4'h0, 16'h8000, 16'h8000, 1'b1, 2'b11}, // -65536   R6
    '{1'b0, 1'b0, 4'hF, 16'h4000, 16'h0000, 1'b1, 2'b00}, // 127      R7
    '{1'b0, 1'b0, 4'hF, 16'h4000, 16'h0000, 1'b0, 2'b00}, // -128     R6
    '{1'b0, 1'b0, 4'h3, 16'h8000, 16'h0005, 1'b1, 2'b00}, // 5        R5
    '{1'b0, 1'b1, 4'h1, 16'hC000, 16'h0000, 1'b1, 2'b10}, // -768     R5
    '{1'b1, 1'b0, 4'h0, 16'h0003, 16'h0000, 1'b1, 2'b01}, // -1       R5
    '{1'b0, 1'b0, 4'h0, 16'h8000, 16'hFF00, 1'b1, 2'b00}, // -128     R7
    '{1'b1, 1'b1, 4'hF, 16'hFFFF, 16'h7FFF, 1'b1, 2'b10}  // 98302    R5
  };

  function automatic logic [31:0] model(input vec_t v);
    longint pw, f, s, hi, lo;
    int n, w;
    n  = v.o3 ? 3 : 2;
    pw = longint'(1) << (n * (v.r32 ? 5 : 4));
    f  = (pw * (2 * $countones(v.pt) - 4)) / 4;
    s  = (f * longint'(v.g)) >>> 15;
    s  = s + longint'($signed(v.off));
    w  = (v.wl == 2'b00) ? 8 : (v.wl == 2'b01) ? 16 : 32;
    hi = (longint'(1) << (w - 1)) - 1;
    lo = -hi - 1;
    if (v.clip) begin
      if (s > hi) s = hi;
      if (s < lo) s = lo;
    end else begin
      s = (s <<< (64 - w)) >>> (64 - w);
    end
    return s[31:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%h) expected %0d (0x%h)", req,
               $signed(act), act, $signed(exp), exp);
    end
  endtask

  task automatic wait_valid();
    @(negedge clk);
    while (!sample_valid && !timed_out) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      bit_en = ~bit_en;
      if (bit_en) begin
        bit_in = pat[pidx % 4];
        pidx++;
        strobes++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    timed_out = 1'b1;
  end

  initial begin
    repeat (6) @(negedge clk);
    // R8: reset state
    check("R8 valid in reset", {31'd0, sample_valid}, 32'd0);
    check("R8 out in reset", sample_out, 32'd0);
    rst = 1'b0;
    strobes = 0;
    wait_valid();
    checks++;
    if (strobes < 160 || strobes > 163) begin
      errors++;
      $display("FAIL R8 first valid after reset: actual %0d strobes expected 160..163", strobes);
    end
    check("R8 first sample value", sample_out, 32'd32768);

    // R4: reconfiguration to order 2, ratio 16
    @(negedge clk);
    order_sel = 1'b0;
    ratio_sel = 1'b0;
    strobes = 0;
    wait_valid();
    checks++;
    if (strobes < 64 || strobes > 67) begin
      errors++;
      $display("FAIL R4 first valid after change: actual %0d strobes expected 64..67", strobes);
    end
    check("R4 settled value", sample_out, 32'd256);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      order_sel = VECS[i].o3;
      ratio_sel = VECS[i].r32;
      pat       = VECS[i].pt;
      gain      = VECS[i].g;
      offset    = VECS[i].off;
      clip_en   = VECS[i].clip;
      width_sel = VECS[i].wl;
      for (int k = 0; k < 6; k++) wait_valid();
      check($sformatf("R1 R2 R3 R5 R6 R7 vector %0d", i), sample_out, model(VECS[i]));
    end

    if (timed_out) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule